// File: doc/BRIEF.md
# Bit-Test and Decrement Branch Execution Unit

This unit executes the conditional-branch group of a small 8-bit controller core: test a bit and branch if it is set, test a bit and branch if it is clear, test a bit and branch if it is set while also clearing it, and decrement an operand and branch if the result is nonzero. The decoder hands it one complete instruction. That instruction carries the operation, the operand addressing class, the bit index, the operand byte that was already fetched, the current PC, a signed 8-bit displacement, a flag marking an operand held in internal high-speed RAM, and the read and write wait-state counts that the memory system reports.

The unit computes the following PC and any byte to be written back. It then holds the result until the instruction's cycle cost has elapsed, and signals completion with a single-cycle `done`.

Issue uses valid/ready. `in_ready` is high only while the unit is idle. An instruction is taken on a clock edge where both `in_valid` and `in_ready` are high. While busy the unit does not sample `in_valid` or the instruction fields, so the decoder must hold or repeat the instruction until `in_ready` returns. The result side has no back-pressure. The outputs are valid during the `done` cycle and stay unchanged until the next issue.

Top module: `bitbr_unit`

## Requirements
- R1: After reset `in_ready` is 1, `done` is 0 and `wb_en` is 0. An issue (`in_valid` and `in_ready` both 1 at a clock edge) drops `in_ready` until `done`. Instruction fields presented while `in_ready` is 0 have no effect on the result.
- R2: Instruction length is added to the PC. Operation codes are 0 = branch-if-set, 1 = branch-if-clear, 2 = branch-if-set-then-clear, 3 = decrement-and-branch. Class codes are 0 = short direct, 1 = special register, 2 = accumulator, 3 = status word, 4 = indirect, 5 = register B, 6 = register C. Branch-if-set is 4 bytes for class 1 and 3 bytes otherwise. Codes 1 and 2 are 4 bytes for classes 0, 1 and 3, and 3 bytes for classes 2 and 4. Code 3 is 2 bytes for classes 5 and 6, and 3 bytes for class 0.
- R3: A taken branch gives `next_pc` = PC + length + sign-extended displacement. A branch that is not taken gives PC + length. Both wrap modulo 2^16, and `next_pc` stays unchanged while the unit is busy.
- R4: Branch-if-set is taken when bit `in_bit` of the operand is 1. Branch-if-clear is taken when that bit is 0. Neither writes back.
- R5: Branch-if-set-then-clear is taken when the bit is 1, and then writes back the operand with that bit cleared. When the bit is 0 it neither branches nor writes.
- R6: Decrement-and-branch always writes back operand − 1, modulo 256. It branches when that value is nonzero, so an operand of 0x00 writes 0xFF and branches.
- R7: The base cost in clocks, shown as internal/other region, is as follows. Branch-if-set: class 0 8/9, class 1 11, class 2 8, class 3 9, class 4 10/11. Branch-if-clear: class 0 10/11, class 1 11, class 2 8, class 3 11, class 4 10/11. Set-then-clear: class 0 10/12, class 1 12, class 2 8, class 3 12, class 4 10/12. Decrement: classes 5 and 6 6, class 0 8/10. The "other" value applies when `in_int_ram` is 0 for classes 0 and 4.
- R8: For classes 0 and 4 with `in_int_ram` = 0, `rd_wait` is added to the cost. `wr_wait` is also added when the instruction writes back.
- R9: When a taken set-then-clear targets the status word, `flag_we` pulses with `done`. The flags are then taken from the written byte: `flag_z` from bit 6, `flag_ac` from bit 4 and `flag_cy` from bit 0.
- R10: `done` rises exactly cost clocks after the issue edge and lasts one clock. `wb_en` is high only during `done`, and only for an instruction that writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction accepted this edge |
| in_op | input | 2 | Operation code |
| in_mode | input | 3 | Operand addressing class |
| in_bit | input | 3 | Bit index to test or clear |
| in_operand | input | 8 | Fetched operand byte |
| in_pc | input | 16 | PC of the instruction |
| in_disp | input | 8 | Signed branch displacement |
| in_int_ram | input | 1 | Operand lies in internal high-speed RAM |
| rd_wait | input | 4 | External read wait cycles |
| wr_wait | input | 4 | External write wait cycles |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 16 | Following PC |
| wb_data | output | 8 | Byte to write back |
| wb_en | output | 1 | Write-back strobe, during done only |
| flag_we | output | 1 | Status flags update strobe |
| flag_z | output | 1 | Zero flag from written byte |
| flag_ac | output | 1 | Auxiliary-carry flag from written byte |
| flag_cy | output | 1 | Carry flag from written byte |

## Verification
The bench builds the unit with its default parameters: 16-bit PC, 8-bit data and 4-bit wait counts. With these widths the longest cost is 12 + 15 + 15 = 42 clocks, and the PC wrap at 0xFFFF falls within a few vectors. The vectors cover every operation, a cost in every addressing class, both halves of the region split, and the read-only and read-write wait paths. They include a status-word clear with its flags, a 0x00 decrement and the most negative displacement. A separate directed run changes the instruction fields while the unit is busy.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;

  typedef enum logic [1:0] {
    OP_BT    = 2'd0,
    OP_BF    = 2'd1,
    OP_BTCLR = 2'd2,
    OP_DBNZ  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    AM_SADDR = 3'd0,
    AM_SFR   = 3'd1,
    AM_ACC   = 3'd2,
    AM_PSW   = 3'd3,
    AM_IND   = 3'd4,
    AM_REGB  = 3'd5,
    AM_REGC  = 3'd6
  } mode_e;

endpackage

// File: rtl/bitbr_eval.sv
module bitbr_eval
  import bitbr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  op_e               op,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] operand,
  output logic              taken,
  output logic              writes,
  output logic [DATA_W-1:0] wb_value
);

  logic [DATA_W-1:0] sel_mask;
  logic [DATA_W-1:0] dec_val;
  logic              bit_val;

  // one-hot bit selector
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign sel_mask[g] = (bit_idx == BIT_W'(g));
  end

  assign bit_val = |(operand & sel_mask);
  assign dec_val = operand - DATA_W'(1);

  always_comb begin
    taken    = 1'b0;
    writes   = 1'b0;
    wb_value = operand;
    case (op)
      OP_BT: taken = bit_val;
      OP_BF: taken = ~bit_val;
      OP_BTCLR: begin
        taken    = bit_val;
        writes   = bit_val;
        wb_value = operand & ~sel_mask;
      end
      default: begin
        writes   = 1'b1;
        wb_value = dec_val;
        taken    = |dec_val;
      end
    endcase
  end

endmodule

// File: rtl/bitbr_cost.sv
module bitbr_cost
  import bitbr_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 6
) (
  input  op_e               op,
  input  mode_e             mode,
  input  logic              int_ram,
  input  logic              writes,
  input  logic [WAIT_W-1:0] rd_wait,
  input  logic [WAIT_W-1:0] wr_wait,
  output logic [2:0]        len,
  output logic [CNT_W-1:0]  cycles
);

  logic [3:0] c_int;
  logic [3:0] c_ext;
  logic       ext_path;

  always_comb begin
    len   = 3'd3;
    c_int = 4'd8;
    c_ext = 4'd8;
    case (op)
      OP_BT: begin
        case (mode)
          AM_SADDR: begin c_int = 4'd8;  c_ext = 4'd9;  end
          AM_SFR:   begin len = 3'd4; c_int = 4'd11; c_ext = 4'd11; end
          AM_PSW:   begin c_int = 4'd9;  c_ext = 4'd9;  end
          AM_IND:   begin c_int = 4'd10; c_ext = 4'd11; end
          default:  begin c_int = 4'd8;  c_ext = 4'd8;  end
        endcase
      end
      OP_BF: begin
        case (mode)
          AM_SADDR: begin len = 3'd4; c_int = 4'd10; c_ext = 4'd11; end
          AM_SFR:   begin len = 3'd4; c_int = 4'd11; c_ext = 4'd11; end
          AM_PSW:   begin len = 3'd4; c_int = 4'd11; c_ext = 4'd11; end
          AM_IND:   begin c_int = 4'd10; c_ext = 4'd11; end
          default:  begin c_int = 4'd8;  c_ext = 4'd8;  end
        endcase
      end
      OP_BTCLR: begin
        case (mode)
          AM_SADDR: begin len = 3'd4; c_int = 4'd10; c_ext = 4'd12; end
          AM_SFR:   begin len = 3'd4; c_int = 4'd12; c_ext = 4'd12; end
          AM_PSW:   begin len = 3'd4; c_int = 4'd12; c_ext = 4'd12; end
          AM_IND:   begin c_int = 4'd10; c_ext = 4'd12; end
          default:  begin c_int = 4'd8;  c_ext = 4'd8;  end
        endcase
      end
      default: begin
        case (mode)
          AM_SADDR: begin c_int = 4'd8; c_ext = 4'd10; end
          default:  begin len = 3'd2; c_int = 4'd6; c_ext = 4'd6; end
        endcase
      end
    endcase
  end

  assign ext_path = ((mode == AM_SADDR) || (mode == AM_IND)) && !int_ram;

  always_comb begin
    if (ext_path)
      cycles = CNT_W'(c_ext) + CNT_W'(rd_wait)
             + (writes ? CNT_W'(wr_wait) : CNT_W'(0));
    else
      cycles = CNT_W'(c_int);
  end

endmodule

// File: rtl/bitbr_timer.sv
module bitbr_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= load;
      end else if (busy) begin
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/bitbr_unit.sv
module bitbr_unit
  import bitbr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int DISP_W = 8,
  parameter int WAIT_W = 4,
  parameter int Z_POS  = 6,
  parameter int AC_POS = 4,
  parameter int CY_POS = 0,
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int MAX_CYC = 12 + 2 * ((1 << WAIT_W) - 1),
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [2:0]        in_mode,
  input  logic [BIT_W-1:0]  in_bit,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [DISP_W-1:0] in_disp,
  input  logic              in_int_ram,
  input  logic [WAIT_W-1:0] rd_wait,
  input  logic [WAIT_W-1:0] wr_wait,
  output logic              done,
  output logic [PC_W-1:0]   next_pc,
  output logic [DATA_W-1:0] wb_data,
  output logic              wb_en,
  output logic              flag_we,
  output logic              flag_z,
  output logic              flag_ac,
  output logic              flag_cy
);

  op_e               op;
  mode_e             mode;
  logic              taken;
  logic              writes;
  logic [DATA_W-1:0] wb_value;
  logic [2:0]        len;
  logic [CNT_W-1:0]  cycles;
  logic              busy;
  logic              start;
  logic [PC_W-1:0]   disp_ext;
  logic [PC_W-1:0]   pc_calc;
  logic              wr_q;
  logic              psw_q;

  assign op    = op_e'(in_op);
  assign mode  = mode_e'(in_mode);
  assign start = in_valid && !busy;

  bitbr_eval #(.DATA_W(DATA_W)) u_eval (
    .op       (op),
    .bit_idx  (in_bit),
    .operand  (in_operand),
    .taken    (taken),
    .writes   (writes),
    .wb_value (wb_value)
  );

  bitbr_cost #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_cost (
    .op      (op),
    .mode    (mode),
    .int_ram (in_int_ram),
    .writes  (writes),
    .rd_wait (rd_wait),
    .wr_wait (wr_wait),
    .len     (len),
    .cycles  (cycles)
  );

  bitbr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (cycles),
    .busy  (busy),
    .done  (done)
  );

  assign disp_ext = {{(PC_W - DISP_W){in_disp[DISP_W-1]}}, in_disp};
  assign pc_calc  = in_pc + PC_W'(len) + (taken ? disp_ext : PC_W'(0));

  // result registers, captured on issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc <= '0;
      wb_data <= '0;
      wr_q    <= 1'b0;
      psw_q   <= 1'b0;
    end else if (start) begin
      next_pc <= pc_calc;
      wb_data <= wb_value;
      wr_q    <= writes;
      psw_q   <= writes && (op == OP_BTCLR) && (mode == AM_PSW);
    end
  end

  assign in_ready = !busy;
  assign wb_en    = done && wr_q;
  assign flag_we  = done && psw_q;
  assign flag_z   = wb_data[Z_POS];
  assign flag_ac  = wb_data[AC_POS];
  assign flag_cy  = wb_data[CY_POS];

endmodule

// File: rtl/bitbr_unit_chk.sv
module bitbr_unit_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            done,
  input logic            wb_en,
  input logic            flag_we,
  input logic [PC_W-1:0] next_pc
);

  p_issue_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(next_pc));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_wb_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  p_flag_with_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> wb_en);

endmodule

bind bitbr_unit bitbr_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .wb_en    (wb_en),
  .flag_we  (flag_we),
  .next_pc  (next_pc)
);

// File: tb/bitbr_unit_bench.sv
`timescale 1ns/1ps
module bitbr_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [2:0]  in_mode = '0;
  logic [2:0]  in_bit = '0;
  logic [7:0]  in_operand = '0;
  logic [15:0] in_pc = '0;
  logic [7:0]  in_disp = '0;
  logic        in_int_ram = 1'b0;
  logic [3:0]  rd_wait = '0;
  logic [3:0]  wr_wait = '0;
  logic        done;
  logic [15:0] next_pc;
  logic [7:0]  wb_data;
  logic        wb_en;
  logic        flag_we;
  logic        flag_z;
  logic        flag_ac;
  logic        flag_cy;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bitbr_unit u_bitbr_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_mode(in_mode), .in_bit(in_bit), .in_operand(in_operand),
    .in_pc(in_pc), .in_disp(in_disp), .in_int_ram(in_int_ram),
    .rd_wait(rd_wait), .wr_wait(wr_wait), .done(done), .next_pc(next_pc),
    .wb_data(wb_data), .wb_en(wb_en), .flag_we(flag_we),
    .flag_z(flag_z), .flag_ac(flag_ac), .flag_cy(flag_cy)
  );

  // op mode bit operand pc disp intram rdw wrw | exp_pc exp_wb exp_we exp_cyc
  localparam int NV = 11;
  localparam logic [79:0] VEC [NV] = '{
    {2'd0,3'd2,3'd3,8'h08,16'h1000,8'h10,1'b1,4'd0,4'd0, 16'h1013,8'h00,1'b0,6'd8},  // R4 BT acc taken
    {2'd0,3'd1,3'd0,8'hFE,16'h1000,8'h10,1'b1,4'd0,4'd0, 16'h1004,8'h00,1'b0,6'd11}, // R2 BT sfr not taken
    {2'd1,3'd3,3'd7,8'h00,16'h1000,8'hF0,1'b1,4'd0,4'd0, 16'h0FF4,8'h00,1'b0,6'd11}, // R3 BF psw negative disp
    {2'd2,3'd0,3'd5,8'h20,16'h1000,8'h05,1'b1,4'd0,4'd0, 16'h1009,8'h00,1'b1,6'd10}, // R5 clear taken
    {2'd2,3'd4,3'd1,8'h01,16'h1000,8'h05,1'b0,4'd2,4'd3, 16'h1003,8'h00,1'b0,6'd14}, // R5 R8 clear not taken
    {2'd3,3'd5,3'd0,8'h01,16'h1000,8'h20,1'b1,4'd0,4'd0, 16'h1002,8'h00,1'b1,6'd6},  // R6 B reaches zero
    {2'd3,3'd6,3'd0,8'h00,16'h1000,8'h80,1'b1,4'd0,4'd0, 16'h0F82,8'hFF,1'b1,6'd6},  // R6 0x00 wraps
    {2'd3,3'd0,3'd0,8'h05,16'hFFFE,8'h7F,1'b0,4'd1,4'd2, 16'h0080,8'h04,1'b1,6'd13}, // R3 R8 pc wrap
    {2'd1,3'd4,3'd2,8'h00,16'h1000,8'h02,1'b1,4'd0,4'd0, 16'h1005,8'h00,1'b0,6'd10}, // R7 BF indirect
    {2'd0,3'd0,3'd7,8'h80,16'h1000,8'h00,1'b0,4'd3,4'd5, 16'h1003,8'h00,1'b0,6'd12}, // R8 read wait only
    {2'd2,3'd3,3'd6,8'h51,16'h1000,8'h00,1'b1,4'd0,4'd0, 16'h1004,8'h11,1'b1,6'd12}  // R9 psw flags
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [79:0] v, input bit disturb);
    int cyc;
    bit fwe;
    @(negedge clk);
    in_op = v[79:78]; in_mode = v[77:75]; in_bit = v[74:72];
    in_operand = v[71:64]; in_pc = v[63:48]; in_disp = v[47:40];
    in_int_ram = v[39]; rd_wait = v[38:35]; wr_wait = v[34:31];
    in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R1", "ready after issue", 32'(in_ready), 0);
    cyc = 0;
    if (disturb) begin
      in_op = 2'd3; in_mode = 3'd5; in_operand = 8'h33; in_pc = 16'h2222;
      in_disp = 8'h44;
    end else begin
      in_valid = 1'b0;
    end
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc == 3) in_valid = 1'b0;
    end
    chk(cyc == int'(v[5:0]), "R7", "cycles to done", 32'(cyc), 32'(v[5:0]));
    chk(next_pc == v[30:15], disturb ? "R1" : "R3", "next_pc", 32'(next_pc), 32'(v[30:15]));
    chk(wb_en == v[6], "R10", "wb_en", 32'(wb_en), 32'(v[6]));
    if (v[6])
      chk(wb_data == v[14:7], "R6", "wb_data", 32'(wb_data), 32'(v[14:7]));
    fwe = (v[79:78] == 2'd2) && (v[77:75] == 3'd3) && v[6];
    chk(flag_we == fwe, "R9", "flag_we", 32'(flag_we), 32'(fwe));
    if (fwe)
      chk({flag_z, flag_ac, flag_cy} == {v[13], v[11], v[7]}, "R9", "flags",
          32'({flag_z, flag_ac, flag_cy}), 32'({v[13], v[11], v[7]}));
    @(negedge clk);
    chk(done == 1'b0 && wb_en == 1'b0, "R10", "pulse end", 32'({done, wb_en}), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "reset ready", 32'(in_ready), 1);
    chk(done == 1'b0, "R1", "reset done", 32'(done), 0);
    chk(wb_en == 1'b0, "R1", "reset wb_en", 32'(wb_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready idle", 32'(in_ready), 1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R1: fields changed during busy are ignored
    run_vec(VEC[0], 1'b1);
    // R5: repeat clear on a write region to confirm stable behaviour
    run_vec(VEC[3], 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule